// File: doc/BRIEF.md
# Network Controller Register Bring-Up Sequencer

This block brings a register-mapped Ethernet controller from its power-on defaults to an online state without help from a processor. After a single start pulse it acts as master on a simple synchronous slave bus (register address, byte data, chip select and write strobe) and issues a fixed series of register writes. The series covers bus-interface setup, FIFO setup, interrupt masking, line-port selection and PHY setup. It then loads a station address and ends with the write that enables transmit and receive.

One mode input, sampled at start, picks what the address-load phase writes. With the mode low it writes a 48-bit physical station address as 6 byte writes. With the mode high it writes a 64-bit multicast hash filter as 8 byte writes. In both cases the lowest byte is written first. Every write takes four bus clocks: one clock sets up the address and data, then three clocks hold chip select and the write strobe. A busy flag covers the whole series, and a one-clock done pulse marks its end.

Top module: `lanctl_init_seq`

## Requirements
- R1: While reset is held, and in the first clock after it is released, busy, done, chip select and write strobe are low, and the bus address and data are zero.
- R2: One run issues exactly 13 writes with the mode low, or 15 with it high. The register addresses are used in this order: 0x11, 0x0F, 0x09, 0x0E, 0x0C, 0x12, then the address-data register repeated, then 0x0D.
- R3: The bus-interface write (0x11) carries 0x31: bit 0 selects big-endian byte swap, and bits 5:4 = 3 select a 112-byte transmit start point. The FIFO write (0x0F) carries 0x0F: both watermark fields (bits 7:6 transmit, 5:4 receive) are 0, giving 8 cycles and 16 bytes; bits 3:2 are the update bits; bits 1:0 enable transmit and receive burst.
- R4: The interrupt-mask write (0x09) carries 0xFF, so all interrupts are masked. The line-interface write (0x0E) carries 0x02, selecting the twisted-pair port. The PHY write (0x0C) carries 0x07: bit 0 link test, bit 1 automatic polarity correction, bit 2 automatic port selection.
- R5: The address-change write (0x12) carries 0x84 with the mode low (bit 7 change request, bit 2 physical address) and 0x82 with the mode high (bit 1 logical address).
- R6: The address bytes go to register 0x15 with the mode low and to 0x14 with it high. They are taken from the 64-bit value input from bits 7:0 upward, lowest byte first. With the mode low, bits 63:48 are ignored.
- R7: The last write goes to 0x0D with data 0x03, enabling transmit (bit 1) and receive (bit 0).
- R8: Each write spans 4 clocks. In the first, address and data are valid while chip select and write strobe are low. In the next three, chip select and write strobe are high and address and data stay unchanged.
- R9: Busy rises in the clock after an accepted start and stays high for 4 clocks per write. In the clock where busy falls, done is high for exactly one clock. Outside a run, address and data are zero.
- R10: A start seen while busy is ignored. Mode and value are captured when the start is accepted, so changes to them during a run have no effect. A start in the done clock is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to run the bring-up series |
| mcast_i | input | 1 | 1: load the multicast filter, 0: load the physical address |
| addr_val_i | input | 64 | Station address (bits 47:0) or filter (bits 63:0) |
| busy_o | output | 1 | Series in progress |
| done_o | output | 1 | One-clock pulse at the end of the series |
| bus_addr_o | output | 5 | Register address on the slave bus |
| bus_data_o | output | 8 | Write data on the slave bus |
| bus_cs_o | output | 1 | Chip select, active high |
| bus_wr_o | output | 1 | Write strobe, active high |

## Verification
The bench builds the block with its default parameters: 6 physical-address bytes, 8 filter bytes and 4 clocks per write. With these, both address-load lengths run end to end, and the exact clock in which busy falls and done pulses is compared against the bench's own model. The defaults also allow a start held through a whole run, so the ignore-while-busy rule and the re-acceptance in the done clock are both exercised. A physical-mode value with nonzero upper bytes shows that only the six low bytes reach the bus.

// File: rtl/lanctl_init_pkg.sv
// Shared constants and types for the controller bring-up sequencer.
// Assumes a 5-bit register address space and byte-wide register data.
package lanctl_init_pkg;

    localparam int REG_AW = 5;
    localparam int REG_DW = 8;
    localparam int FIXED_STEPS = 6;   // writes before the address bytes

    typedef struct packed {
        logic [REG_AW-1:0] addr;
        logic [REG_DW-1:0] data;
    } wr_item_t;

    // register addresses
    localparam logic [REG_AW-1:0] RA_BUSCFG  = 5'h11;
    localparam logic [REG_AW-1:0] RA_FIFOCFG = 5'h0F;
    localparam logic [REG_AW-1:0] RA_IRQMASK = 5'h09;
    localparam logic [REG_AW-1:0] RA_LINECFG = 5'h0E;
    localparam logic [REG_AW-1:0] RA_PHYCFG  = 5'h0C;
    localparam logic [REG_AW-1:0] RA_ADRCHG  = 5'h12;
    localparam logic [REG_AW-1:0] RA_PHYSADR = 5'h15;
    localparam logic [REG_AW-1:0] RA_FILTER  = 5'h14;
    localparam logic [REG_AW-1:0] RA_MACCFG  = 5'h0D;

    // register contents
    localparam logic [REG_DW-1:0] RD_BUSCFG  = 8'h31;
    localparam logic [REG_DW-1:0] RD_FIFOCFG = 8'h0F;
    localparam logic [REG_DW-1:0] RD_IRQMASK = 8'hFF;
    localparam logic [REG_DW-1:0] RD_LINECFG = 8'h02;
    localparam logic [REG_DW-1:0] RD_PHYCFG  = 8'h07;
    localparam logic [REG_DW-1:0] RD_ADR_PHY = 8'h84;
    localparam logic [REG_DW-1:0] RD_ADR_LOG = 8'h82;
    localparam logic [REG_DW-1:0] RD_MACCFG  = 8'h03;

    // Returns the fixed write for steps 0..FIXED_STEPS-1.
    function automatic wr_item_t fixed_write(input int unsigned idx, input logic mcast);
        wr_item_t w;
        case (idx)
            0:       w = '{addr: RA_BUSCFG,  data: RD_BUSCFG};
            1:       w = '{addr: RA_FIFOCFG, data: RD_FIFOCFG};
            2:       w = '{addr: RA_IRQMASK, data: RD_IRQMASK};
            3:       w = '{addr: RA_LINECFG, data: RD_LINECFG};
            4:       w = '{addr: RA_PHYCFG,  data: RD_PHYCFG};
            default: w = '{addr: RA_ADRCHG,  data: mcast ? RD_ADR_LOG : RD_ADR_PHY};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/lanctl_wr_phase.sv
// Clock-phase counter for one bus write.
// Phase 0 is address setup; phases 1..CYCLE_CLKS-1 assert the strobes.
// Assumes run stays high for whole multiples of CYCLE_CLKS clocks.
module lanctl_wr_phase #(
    parameter int CYCLE_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic strobe,
    output logic last_phase
);
    localparam int PH_W = (CYCLE_CLKS > 2) ? $clog2(CYCLE_CLKS) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYCLE_CLKS - 1);

    logic [PH_W-1:0] phase_q;

    // Advance the phase while running, wrap after the last phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase_q <= '0;
        end else if (phase_q == PH_LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // Decode the strobe window and the final phase.
    always_comb begin
        strobe     = run && (phase_q != '0);
        last_phase = run && (phase_q == PH_LAST);
    end

    // R8
    phase_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (phase_q == '0));

endmodule

// File: rtl/lanctl_init_rom.sv
// Maps a step index of the bring-up series to a register write.
// Assumes step never exceeds the final MAC-enable step for the mode given.
module lanctl_init_rom
    import lanctl_init_pkg::*;
#(
    parameter int PHYS_BYTES = 6,
    parameter int FILT_BYTES = 8,
    parameter int STEP_W     = 4
) (
    input  logic [STEP_W-1:0]       step,
    input  logic                    mcast,
    input  logic [FILT_BYTES*8-1:0] value,
    output wr_item_t                item
);
    localparam logic [STEP_W-1:0] FIX_END = STEP_W'(FIXED_STEPS);

    logic [STEP_W-1:0] byte_idx;
    logic [STEP_W-1:0] byte_end;
    logic [REG_DW-1:0] byte_val;

    // Select the address byte addressed by the current step.
    always_comb begin
        byte_idx = step - FIX_END;
        byte_end = FIX_END + (mcast ? STEP_W'(FILT_BYTES) : STEP_W'(PHYS_BYTES));
        byte_val = '0;
        for (int b = 0; b < FILT_BYTES; b++) begin
            if (byte_idx == STEP_W'(b)) byte_val = value[b*8 +: 8];
        end
    end

    // Choose fixed, address-byte or final write for the step.
    always_comb begin
        if (step < FIX_END) begin
            item = fixed_write(int'(step), mcast);
        end else if (step < byte_end) begin
            item = '{addr: mcast ? RA_FILTER : RA_PHYSADR, data: byte_val};
        end else begin
            item = '{addr: RA_MACCFG, data: RD_MACCFG};
        end
    end

endmodule

// File: rtl/lanctl_init_seq.sv
// Top of the controller bring-up sequencer.
// On an accepted start it captures mode and value, walks every step of
// the series with one CYCLE_CLKS-long write each, then pulses done.
// Assumes the slave bus accepts a write in the fixed cycle length.
module lanctl_init_seq
    import lanctl_init_pkg::*;
#(
    parameter int PHYS_BYTES = 6,
    parameter int FILT_BYTES = 8,
    parameter int CYCLE_CLKS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    mcast_i,
    input  logic [FILT_BYTES*8-1:0] addr_val_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic [REG_AW-1:0]       bus_addr_o,
    output logic [REG_DW-1:0]       bus_data_o,
    output logic                    bus_cs_o,
    output logic                    bus_wr_o
);
    localparam int MAX_STEPS = FIXED_STEPS + FILT_BYTES + 1;
    localparam int STEP_W    = $clog2(MAX_STEPS + 1);
    localparam logic [STEP_W-1:0] LAST_PHYS = STEP_W'(FIXED_STEPS + PHYS_BYTES);
    localparam logic [STEP_W-1:0] LAST_FILT = STEP_W'(FIXED_STEPS + FILT_BYTES);

    logic                    busy_q;
    logic                    done_q;
    logic                    mcast_q;
    logic [STEP_W-1:0]       step_q;
    logic [FILT_BYTES*8-1:0] value_q;
    logic                    strobe;
    logic                    last_phase;
    logic                    last_step;
    wr_item_t                item;

    lanctl_wr_phase #(.CYCLE_CLKS(CYCLE_CLKS)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (busy_q),
        .strobe     (strobe),
        .last_phase (last_phase)
    );

    lanctl_init_rom #(
        .PHYS_BYTES (PHYS_BYTES),
        .FILT_BYTES (FILT_BYTES),
        .STEP_W     (STEP_W)
    ) u_rom (
        .step  (step_q),
        .mcast (mcast_q),
        .value (value_q),
        .item  (item)
    );

    // Flag the final step of the series for the captured mode.
    always_comb begin
        last_step = (step_q == (mcast_q ? LAST_FILT : LAST_PHYS));
    end

    // Accept start when idle, step through writes, end with a done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            mcast_q <= 1'b0;
            step_q  <= '0;
            value_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start_i) begin
                    busy_q  <= 1'b1;
                    step_q  <= '0;
                    mcast_q <= mcast_i;
                    value_q <= addr_val_i;
                end
            end else if (last_phase) begin
                if (last_step) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    step_q <= '0;
                end else begin
                    step_q <= step_q + 1'b1;
                end
            end
        end
    end

    // Drive the bus; address and data read zero outside a run.
    always_comb begin
        busy_o     = busy_q;
        done_o     = done_q;
        bus_addr_o = busy_q ? item.addr : '0;
        bus_data_o = busy_q ? item.data : '0;
        bus_cs_o   = strobe;
        bus_wr_o   = strobe;
    end

    // R8
    hold_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs_o |-> ($stable(bus_addr_o) && $stable(bus_data_o)));

    // R8
    setup_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cs_o) |-> ($past(busy_o) && !$past(bus_cs_o)));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o) && !bus_cs_o));

    // R10
    mode_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(mcast_q) && $stable(value_q)));

endmodule

// File: tb/lanctl_init_seq_test.sv
`timescale 1ns/1ps
module lanctl_init_seq_test;

    typedef struct {
        bit          wr;
        bit          dn;
        bit          cs;
        logic [4:0]  a;
        logic [7:0]  d;
        int          n;
        string       tag;
    } entry_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        mcast_i = 1'b0;
    logic [63:0] addr_val_i = '0;
    logic        busy_o, done_o, bus_cs_o, bus_wr_o;
    logic [4:0]  bus_addr_o;
    logic [7:0]  bus_data_o;

    int     n_chk = 0;
    int     n_fail = 0;
    int     wr_seen = 0;
    bit     prev_cs = 1'b0;
    bit     in_reset = 1'b1;
    bit     finished = 1'b0;
    entry_t exp_q[$];

    always #2 clk = ~clk;

    lanctl_init_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mcast_i(mcast_i),
        .addr_val_i(addr_val_i), .busy_o(busy_o), .done_o(done_o),
        .bus_addr_o(bus_addr_o), .bus_data_o(bus_data_o),
        .bus_cs_o(bus_cs_o), .bus_wr_o(bus_wr_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic add_write(input logic [4:0] a, input logic [7:0] d, input string tag);
        for (int ph = 0; ph < 4; ph++)
            exp_q.push_back('{wr: 1, dn: 0, cs: (ph != 0), a: a, d: d, n: 0, tag: tag});
    endtask

    // Expected series built from R2..R7; 'over' relabels it for R10 runs.
    task automatic push_seq(input bit mc, input logic [63:0] val, input string over);
        int nb = mc ? 8 : 6;
        add_write(5'h11, 8'h31, over != "" ? over : "R3");
        add_write(5'h0F, 8'h0F, over != "" ? over : "R3");
        add_write(5'h09, 8'hFF, over != "" ? over : "R4");
        add_write(5'h0E, 8'h02, over != "" ? over : "R4");
        add_write(5'h0C, 8'h07, over != "" ? over : "R4");
        add_write(5'h12, mc ? 8'h82 : 8'h84, over != "" ? over : "R5");
        for (int b = 0; b < nb; b++)
            add_write(mc ? 5'h14 : 5'h15, val[b*8 +: 8], over != "" ? over : "R6");
        add_write(5'h0D, 8'h03, over != "" ? over : "R7");
        exp_q.push_back('{wr: 0, dn: 1, cs: 0, a: 0, d: 0, n: nb + 7, tag: "R9"});
    endtask

    // One clock: compare outputs with the model, then drive the next inputs.
    task automatic tick(input bit st, input bit mc, input logic [63:0] val, input string over);
        entry_t e;
        string  t;
        @(negedge clk);
        if (exp_q.size() > 0) e = exp_q.pop_front();
        else e = '{wr: 0, dn: 0, cs: 0, a: 0, d: 0, n: 0, tag: in_reset ? "R1" : "R9"};
        t = in_reset ? "R1" : "R9";
        check(busy_o === e.wr, t, "busy", 64'(busy_o), 64'(e.wr));
        check(done_o === e.dn, t, "done", 64'(done_o), 64'(e.dn));
        t = in_reset ? "R1" : "R8";
        check(bus_cs_o === e.cs, t, "chip select", 64'(bus_cs_o), 64'(e.cs));
        check(bus_wr_o === e.cs, t, "write strobe", 64'(bus_wr_o), 64'(e.cs));
        check(bus_addr_o === e.a, e.tag, "address", 64'(bus_addr_o), 64'(e.a));
        check(bus_data_o === e.d, e.tag, "data", 64'(bus_data_o), 64'(e.d));
        if (bus_cs_o && !prev_cs) wr_seen++;
        prev_cs = bus_cs_o;
        if (e.dn) begin
            // R2: write count of the finished run
            check(wr_seen == e.n, "R2", "write count", 64'(wr_seen), 64'(e.n));
        end
        if (e.dn || !e.wr) wr_seen = 0;
        start_i    = st;
        mcast_i    = mc;
        addr_val_i = val;
        if (st && exp_q.size() == 0 && !in_reset) push_seq(mc, val, over);
    endtask

    task automatic drain(input bit mc, input logic [63:0] val);
        while (exp_q.size() != 0) tick(1'b0, mc, val, "");
    endtask

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, 64'h0, "");
        in_reset = 1'b0;
        rst_n = 1'b1;
        tick(1'b0, 1'b0, 64'h0, "");
        tick(1'b0, 1'b0, 64'h0, "");
        // R6: physical mode, upper bytes must not appear
        tick(1'b1, 1'b0, 64'hA1B2_C3D4_E5F6_0718, "");
        drain(1'b0, 64'h0);
        tick(1'b0, 1'b0, 64'h0, "");
        // R5 R6: multicast filter, 8 bytes
        tick(1'b1, 1'b1, 64'h0123_4567_89AB_CDEF, "");
        drain(1'b1, 64'h0);
        tick(1'b0, 1'b0, 64'h0, "");
        // R10: start, mode and value changes during busy are ignored
        tick(1'b1, 1'b0, 64'h0000_1122_3344_5566, "R10");
        for (int i = 0; i < 20; i++) tick(i[0], 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, "");
        drain(1'b1, 64'hDEAD_BEEF_0000_0000);
        // R10: start held high; re-accepted in the done clock
        tick(1'b1, 1'b1, 64'h8877_6655_4433_2211, "R10");
        for (int i = 0; i < 61; i++) tick(1'b1, 1'b1, 64'h8877_6655_4433_2211, "R10");
        drain(1'b1, 64'h0);
        tick(1'b0, 1'b0, 64'h0, "");
        tick(1'b0, 1'b0, 64'h0, "");
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #400000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9 watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule